// File: doc/BRIEF.md
# Exception Priority and Vector Unit

This unit chooses which exception a small 32-bit processor core enters next. Every clock it looks at the raised exception sources and at the core's current interrupt-disable and fast-interrupt-disable flags. It picks one source by a fixed ranking and then produces four results: a one-cycle take strobe, the byte address of the handler vector, the 5-bit processor mode to switch to, and the disable flags the core must write back on entry.

Synchronous faults arrive as one-cycle pulses: data abort, prefetch abort, undefined instruction, software interrupt and the 26-bit address exception. The unit latches each of them until it is entered. The two interrupt lines are levels and are never latched. When a higher-ranked entry leaves a lower-ranked request waiting, the unit enters the waiting request at the next opportunity, two clocks later. The important case is a data abort that coincides with an unmasked fast interrupt. The data abort is entered first and leaves the fast-interrupt-disable flag untouched, so the fast interrupt follows straight after. The reset request outranks everything else. While it is held, all other sources are silenced.

Top module: `exc_arbiter`

## Requirements
- R1: When several sources are eligible in the same cycle, the unit enters exactly one of them, in this order from highest to lowest: reset, data abort, address exception, fast interrupt, normal interrupt, prefetch abort, then undefined instruction or software interrupt.
- R2: The vector output equals VEC_BASE plus a fixed byte offset: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, address exception 0x14, normal interrupt 0x18, fast interrupt 0x1C.
- R3: The mode output on entry is 5'b10011 for reset, software interrupt and address exception; 5'b11011 for undefined; 5'b10111 for either abort; 5'b10010 for normal interrupt; 5'b10001 for fast interrupt.
- R4: An address exception request is latched only while cfg_addr26 is 1. When cfg_addr26 is 0, the request is dropped and produces no entry, either in that cycle or later.
- R5: A fast interrupt is eligible only when the effective F flag is 0, and a normal interrupt only when the effective I flag is 0. The effective flags are the unit's own flag outputs in the second cycle after a take, and are flag_f_in and flag_i_in otherwise.
- R6: On every entry flag_i_out becomes 1. flag_f_out becomes 1 on reset and fast-interrupt entry, and otherwise keeps the effective F value.
- R7: A data abort that coincides with an enabled fast interrupt is entered first, with flag_f_out left at 0. If the fast interrupt is still raised, it is then entered on the take two cycles later.
- R8: take is high for one cycle, in the cycle after the request is sampled, and is never high in two consecutive cycles. vec_addr, mode_out and both flag outputs change only together with take, and hold their values between takes.
- R9: A pulsed synchronous request that cannot be entered at once stays pending until it is entered. The interrupt lines are not latched.
- R10: A rising edge of req_reset produces exactly one reset entry. While req_reset is 1, no other source is entered, and all other pending requests are discarded.
- R11: Undefined instruction and software interrupt must never be requested in the same cycle. The checker flags it if they are.
- R12: While rst_n is 0, take is 0, vec_addr is VEC_BASE, mode_out is 5'b10011, and both flag outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| req_reset | input | 1 | Reset exception request (level) |
| req_dabort | input | 1 | Data abort pulse |
| req_addrexc | input | 1 | Address exception pulse |
| req_fiq | input | 1 | Fast interrupt level |
| req_irq | input | 1 | Normal interrupt level |
| req_pabort | input | 1 | Prefetch abort pulse |
| req_undef | input | 1 | Undefined instruction pulse |
| req_swi | input | 1 | Software interrupt pulse |
| cfg_addr26 | input | 1 | Enables the 26-bit address exception |
| flag_f_in | input | 1 | Core's current fast-interrupt disable flag |
| flag_i_in | input | 1 | Core's current interrupt disable flag |
| take | output | 1 | One-cycle entry strobe |
| vec_addr | output | ADDR_W | Handler vector byte address |
| mode_out | output | 5 | Mode to enter |
| flag_f_out | output | 1 | Fast-interrupt disable flag to write |
| flag_i_out | output | 1 | Interrupt disable flag to write |

## Verification
Each entry appears exactly one clock after the inputs that caused it are sampled. The vector, mode and flags appear in that same registered cycle. The next possible entry comes two clocks after a take, and the blocking and flag forwarding follow that spacing. The bench drives inputs five nanoseconds after each rising edge and runs its reference model one clock ahead. It compares every output in the middle of the following high phase, so the data-abort-then-fast-interrupt pair is expected on two takes exactly two cycles apart. Latched pulses that are blocked are expected on the next permitted take.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int SRC_BITS = 6;  // pending bits: rst, dabt, addr, pabt, und, swi

    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_UND = 5'b11011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_FIQ = 5'b10001;

    typedef enum logic [3:0] {
        SRC_NONE, SRC_RST, SRC_DABT, SRC_ADDR, SRC_FIQ,
        SRC_IRQ,  SRC_PABT, SRC_UND, SRC_SWI
    } exc_src_e;

    // bit positions inside the pending vector
    localparam int PB_RST  = 0;
    localparam int PB_DABT = 1;
    localparam int PB_ADDR = 2;
    localparam int PB_PABT = 3;
    localparam int PB_UND  = 4;
    localparam int PB_SWI  = 5;

    function automatic logic [7:0] vec_offset(exc_src_e s);
        case (s)
            SRC_UND:  return 8'h04;
            SRC_SWI:  return 8'h08;
            SRC_PABT: return 8'h0C;
            SRC_DABT: return 8'h10;
            SRC_ADDR: return 8'h14;
            SRC_IRQ:  return 8'h18;
            SRC_FIQ:  return 8'h1C;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic [4:0] entry_mode(exc_src_e s);
        case (s)
            SRC_UND:           return MODE_UND;
            SRC_PABT, SRC_DABT: return MODE_ABT;
            SRC_IRQ:           return MODE_IRQ;
            SRC_FIQ:           return MODE_FIQ;
            default:           return MODE_SVC;
        endcase
    endfunction

    function automatic logic [SRC_BITS-1:0] pend_bit(exc_src_e s);
        logic [SRC_BITS-1:0] b;
        b = '0;
        case (s)
            SRC_RST:  b[PB_RST]  = 1'b1;
            SRC_DABT: b[PB_DABT] = 1'b1;
            SRC_ADDR: b[PB_ADDR] = 1'b1;
            SRC_PABT: b[PB_PABT] = 1'b1;
            SRC_UND:  b[PB_UND]  = 1'b1;
            SRC_SWI:  b[PB_SWI]  = 1'b1;
            default:  b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/exc_pending.sv
module exc_pending #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] keep_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] cand_o
);
    logic [W-1:0] pend_d, pend_q;

    always_comb begin
        cand_o = (pend_q | set_i) & keep_i;
        pend_d = cand_o & ~clr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end
endmodule

// File: rtl/exc_select.sv
module exc_select
    import exc_pkg::*;
(
    input  logic [SRC_BITS-1:0] cand_i,
    input  logic                fiq_i,
    input  logic                irq_i,
    input  logic                f_eff_i,
    input  logic                i_eff_i,
    input  logic                block_i,
    output exc_src_e            src_o
);
    always_comb begin
        if (block_i)                  src_o = SRC_NONE;
        else if (cand_i[PB_RST])      src_o = SRC_RST;
        else if (cand_i[PB_DABT])     src_o = SRC_DABT;
        else if (cand_i[PB_ADDR])     src_o = SRC_ADDR;
        else if (fiq_i && !f_eff_i)   src_o = SRC_FIQ;
        else if (irq_i && !i_eff_i)   src_o = SRC_IRQ;
        else if (cand_i[PB_PABT])     src_o = SRC_PABT;
        else if (cand_i[PB_UND])      src_o = SRC_UND;
        else if (cand_i[PB_SWI])      src_o = SRC_SWI;
        else                          src_o = SRC_NONE;
    end
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_dabort,
    input  logic              req_addrexc,
    input  logic              req_fiq,
    input  logic              req_irq,
    input  logic              req_pabort,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic              cfg_addr26,
    input  logic              flag_f_in,
    input  logic              flag_i_in,
    output logic              take,
    output logic [ADDR_W-1:0] vec_addr,
    output logic [4:0]        mode_out,
    output logic              flag_f_out,
    output logic              flag_i_out
);
    typedef struct packed {
        logic              take;
        logic [ADDR_W-1:0] vec;
        logic [4:0]        mode;
        logic              f;
        logic              i;
        logic              fwd;    // second cycle after a take
        logic              rseen;  // previous req_reset level
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [SRC_BITS-1:0] set_v, keep_v, clr_v, cand_v;
    logic                f_eff, i_eff, rst_rise;
    exc_src_e            src;

    // request capture
    always_comb begin
        rst_rise = req_reset && !st_q.rseen;
        set_v    = '0;
        set_v[PB_RST]  = rst_rise;
        set_v[PB_DABT] = req_dabort;
        set_v[PB_ADDR] = req_addrexc && cfg_addr26;
        set_v[PB_PABT] = req_pabort;
        set_v[PB_UND]  = req_undef;
        set_v[PB_SWI]  = req_swi;
        keep_v         = '1;
        if (req_reset) begin
            keep_v         = '0;
            keep_v[PB_RST] = 1'b1;
        end
        f_eff = st_q.fwd ? st_q.f : flag_f_in;
        i_eff = st_q.fwd ? st_q.i : flag_i_in;
        clr_v = pend_bit(src);
    end

    exc_pending #(.W(SRC_BITS)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .keep_i (keep_v),
        .clr_i  (clr_v),
        .cand_o (cand_v)
    );

    exc_select u_select (
        .cand_i  (cand_v),
        .fiq_i   (req_fiq && !req_reset),
        .irq_i   (req_irq && !req_reset),
        .f_eff_i (f_eff),
        .i_eff_i (i_eff),
        .block_i (st_q.take),
        .src_o   (src)
    );

    // next-state
    always_comb begin
        st_d       = st_q;
        st_d.take  = (src != SRC_NONE);
        st_d.fwd   = st_q.take;
        st_d.rseen = req_reset;
        if (src != SRC_NONE) begin
            st_d.vec  = VEC_BASE + ADDR_W'(vec_offset(src));
            st_d.mode = entry_mode(src);
            st_d.i    = 1'b1;
            st_d.f    = (src == SRC_RST || src == SRC_FIQ) ? 1'b1 : f_eff;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.take  <= 1'b0;
            st_q.vec   <= VEC_BASE;
            st_q.mode  <= MODE_SVC;
            st_q.f     <= 1'b1;
            st_q.i     <= 1'b1;
            st_q.fwd   <= 1'b0;
            st_q.rseen <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take       = st_q.take;
    assign vec_addr   = st_q.vec;
    assign mode_out   = st_q.mode;
    assign flag_f_out = st_q.f;
    assign flag_i_out = st_q.i;
endmodule

// File: rtl/exc_arbiter_chk.sv
module exc_arbiter_chk
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_reset,
    input logic              req_undef,
    input logic              req_swi,
    input logic              take,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [4:0]        mode_out,
    input logic              flag_f_out,
    input logic              flag_i_out
);
    localparam logic [ADDR_W-1:0] FIQ_VEC = VEC_BASE + ADDR_W'(8'h1C);

    // R8
    take_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);

    // R6
    entry_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> flag_i_out);

    // R6
    fiq_sets_f_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && mode_out == MODE_FIQ) |-> flag_f_out);

    // R2
    fiq_vec_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && vec_addr == FIQ_VEC) |-> (mode_out == MODE_FIQ));

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |-> ($stable(vec_addr) && $stable(mode_out)
                   && $stable(flag_f_out) && $stable(flag_i_out)));

    // R10
    reset_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |=> (!take || (vec_addr == VEC_BASE && mode_out == MODE_SVC)));

    // R11
    und_swi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_undef && req_swi));
endmodule

bind exc_arbiter exc_arbiter_chk #(.ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_reset  (req_reset),
    .req_undef  (req_undef),
    .req_swi    (req_swi),
    .take       (take),
    .vec_addr   (vec_addr),
    .mode_out   (mode_out),
    .flag_f_out (flag_f_out),
    .flag_i_out (flag_i_out)
);

// File: tb/exc_arbiter_bench.sv
module exc_arbiter_bench;
    localparam int S_NONE = 0, S_RST = 1, S_DAB = 2, S_ADR = 3, S_FIQ = 4,
                   S_IRQ = 5, S_PAB = 6, S_UND = 7, S_SWI = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rr = 0, dab = 0, ae = 0, fq = 0, iq = 0, pab = 0, und = 0, swi = 0;
    logic cfg = 0, fin = 0, iin = 0;
    logic        take, f_o, i_o;
    logic [31:0] vec;
    logic [4:0]  mode;

    always #10 clk = ~clk;  // 50 MHz

    exc_arbiter u_exc_arbiter (
        .clk(clk), .rst_n(rst_n), .req_reset(rr), .req_dabort(dab),
        .req_addrexc(ae), .req_fiq(fq), .req_irq(iq), .req_pabort(pab),
        .req_undef(und), .req_swi(swi), .cfg_addr26(cfg),
        .flag_f_in(fin), .flag_i_in(iin), .take(take), .vec_addr(vec),
        .mode_out(mode), .flag_f_out(f_o), .flag_i_out(i_o)
    );

    int n_chk = 0, n_bad = 0;

    // reference model state; pending bits: 0 rst,1 dab,2 adr,3 pab,4 und,5 swi
    logic [5:0]  m_pend = '0;
    logic        m_take = 0, m_f = 1, m_i = 1, m_fwd = 0, m_rseen = 0;
    logic [31:0] m_vec = 0;
    logic [4:0]  m_mode = 5'b10011;

    function automatic logic [31:0] exp_vec(int s);
        case (s)
            S_UND: return 32'h04;  S_SWI: return 32'h08;
            S_PAB: return 32'h0C;  S_DAB: return 32'h10;
            S_ADR: return 32'h14;  S_IRQ: return 32'h18;
            S_FIQ: return 32'h1C;  default: return 32'h00;
        endcase
    endfunction

    function automatic logic [4:0] exp_mode(int s);
        case (s)
            S_UND:        return 5'b11011;
            S_PAB, S_DAB: return 5'b10111;
            S_IRQ:        return 5'b10010;
            S_FIQ:        return 5'b10001;
            default:      return 5'b10011;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(string tag);
        logic [5:0] setv, cand, n_pend;
        logic fe, ie;
        int s;
        if (!rst_n) begin
            n_pend = '0;
            s = S_NONE;
        end else begin
            setv = {swi, und, pab, ae & cfg, dab, rr & !m_rseen};
            cand = m_pend | setv;
            if (rr) cand = cand & 6'b000001;
            fe = m_fwd ? m_f : fin;
            ie = m_fwd ? m_i : iin;
            if (m_take)               s = S_NONE;
            else if (cand[0])         s = S_RST;
            else if (cand[1])         s = S_DAB;
            else if (cand[2])         s = S_ADR;
            else if (fq && !rr && !fe) s = S_FIQ;
            else if (iq && !rr && !ie) s = S_IRQ;
            else if (cand[3])         s = S_PAB;
            else if (cand[4])         s = S_UND;
            else if (cand[5])         s = S_SWI;
            else                      s = S_NONE;
            n_pend = cand;
            case (s)
                S_RST: n_pend[0] = 0;  S_DAB: n_pend[1] = 0;
                S_ADR: n_pend[2] = 0;  S_PAB: n_pend[3] = 0;
                S_UND: n_pend[4] = 0;  S_SWI: n_pend[5] = 0;
                default: ;
            endcase
        end
        @(posedge clk);
        #5;
        if (!rst_n) begin
            m_take = 0; m_vec = 0; m_mode = 5'b10011; m_f = 1; m_i = 1;
            m_fwd = 0; m_rseen = 0;
        end else begin
            m_fwd   = m_take;
            m_rseen = rr;
            m_take  = (s != S_NONE);
            if (s != S_NONE) begin
                m_vec  = exp_vec(s);
                m_mode = exp_mode(s);
                m_i    = 1;
                m_f    = (s == S_RST || s == S_FIQ) ? 1'b1 : fe;
            end
        end
        m_pend = n_pend;
        n_chk++;
        if ({take, vec, mode, f_o, i_o} !== {m_take, m_vec, m_mode, m_f, m_i}) begin
            n_bad++;
            $display("FAIL %s: take/vec/mode/f/i actual %b %h %b %b %b expected %b %h %b %b %b",
                     tag, take, vec, mode, f_o, i_o, m_take, m_vec, m_mode, m_f, m_i);
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        // R12 reset state
        tick("R12"); tick("R12");
        chk("R12 take", {31'd0, take}, 0);
        chk("R12 mode", {27'd0, mode}, 32'h13);
        chk("R12 flags", {30'd0, f_o, i_o}, 3);
        rst_n = 1;
        tick("R12");

        // R7 data abort with enabled fast interrupt
        dab = 1; fq = 1; fin = 0; iin = 0;
        tick("R7");
        chk("R7 first vec", vec, 32'h10);
        chk("R7 first mode", {27'd0, mode}, 32'h17);
        chk("R7 F kept clear", {31'd0, f_o}, 0);
        dab = 0;
        tick("R8");
        chk("R8 no back-to-back take", {31'd0, take}, 0);
        tick("R7");
        chk("R7 second take", {31'd0, take}, 1);
        chk("R7 second vec", vec, 32'h1C);
        chk("R7 second mode", {27'd0, mode}, 32'h11);
        fq = 0;
        tick("R8"); tick("R8");

        // R4 address exception gated by configuration
        ae = 1; cfg = 0;
        tick("R4");
        chk("R4 ignored now", {31'd0, take}, 0);
        ae = 0;
        tick("R4");
        chk("R4 ignored later", {31'd0, take}, 0);
        ae = 1; cfg = 1;
        tick("R4");
        chk("R4 vec", vec, 32'h14);
        chk("R3 addr mode", {27'd0, mode}, 32'h13);
        ae = 0; cfg = 0;
        tick("R4"); tick("R4");

        // R1 and R9: interrupt beats prefetch abort, which stays pending
        pab = 1; iq = 1;
        tick("R1");
        chk("R1 irq first", vec, 32'h18);
        pab = 0; iq = 0;
        tick("R9");
        tick("R9");
        chk("R9 latched pabort vec", vec, 32'h0C);
        chk("R9 latched pabort take", {31'd0, take}, 1);
        tick("R9");

        // R5 masking
        iq = 1; iin = 1;
        tick("R5");
        chk("R5 masked irq", {31'd0, take}, 0);
        iin = 0;
        tick("R5");
        chk("R5 unmasked irq", vec, 32'h18);
        iq = 0;
        tick("R5"); tick("R5");

        // R10 reset request suppresses and flushes
        rr = 1; dab = 1; fq = 1;
        tick("R10");
        chk("R10 reset vec", vec, 32'h00);
        chk("R10 reset flags", {30'd0, f_o, i_o}, 3);
        dab = 0;
        tick("R10");
        tick("R10");
        chk("R10 single entry", {31'd0, take}, 0);
        fq = 0; rr = 0;
        tick("R10");
        chk("R10 flushed abort", {31'd0, take}, 0);
        tick("R10");

        // R2/R3 lowest level
        und = 1;
        tick("R2");
        chk("R2 und vec", vec, 32'h04);
        chk("R3 und mode", {27'd0, mode}, 32'h1B);
        und = 0;
        tick("R2");
        swi = 1;
        tick("R2");
        chk("R2 swi vec", vec, 32'h08);
        swi = 0;
        tick("R2");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            int u;
            rr  = rr ? ($urandom % 4 != 0) : ($urandom % 150 == 0);
            dab = ($urandom % 12 == 0);
            pab = ($urandom % 10 == 0);
            ae  = ($urandom % 14 == 0);
            u   = $urandom % 16;
            und = (u == 0);
            swi = (u == 1);
            if ($urandom % 8 == 0) fq = ~fq;
            if ($urandom % 6 == 0) iq = ~iq;
            if ($urandom % 5 == 0) fin = ~fin;
            if ($urandom % 5 == 0) iin = ~iin;
            if ($urandom % 20 == 0) cfg = ~cfg;
            tick("R1 R2 R3 R5 R6 R9");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule